// File: doc/BRIEF.md
# Counter Compare-Match Set/Reset Unit

This block watches the value of a signed up/down counter and reacts when that value arrives at a programmed compare value. It has a parameterised number of compare slots. Each slot holds its own compare value, an enable and an action. The action can force a driven output bit high, force it low, send a one-clock interrupt request, or do nothing. The counter sits outside this block. It presents each new value together with an update strobe, and the block evaluates every slot in the same cycle as that update. No software polling is involved.

A match is an arrival event. It fires only when an update brings the value onto the compare value from some other value, whether from below, from above or after a wrap of the ring. An update that keeps the value where it was does not fire, and neither does an update that moves it away. The block keeps the last updated value so it can tell these cases apart. When any slot is enabled while the counter itself is disabled, the block raises a configuration error and all slots stay silent.

Top module: `cmpm_top`

## Requirements
- R1: On an update strobe (`cnt_upd`=1), a slot whose new value `cnt_val` equals its compare value matches if either of two conditions holds: the previously updated value was different, or no update has been seen since reset. Arrivals from one below, from one above, and across the signed wrap (0x80000000 to 0x7FFFFFFF) all count as matches.
- R2: No match occurs when the value leaves the compare value, or when an update repeats the compare value. No match occurs in a cycle without a strobe, and in that cycle the outputs hold.
- R3: Slot action code 2'b00 (set) drives that slot's `out_bit` high in the cycle after a match. Action code 2'b01 (clear) drives it low in the cycle after a match. Without a match the bit keeps its state.
- R4: Action code 2'b10 (interrupt) gives exactly one single-cycle `irq` pulse, in the cycle after each match. Two separate arrivals give two pulses, and `irq` is never high in two consecutive cycles.
- R5: Action code 2'b11 (none) and a cleared slot enable both suppress every event of that slot. The slot's `out_bit` keeps its state and its `irq` stays low.
- R6: The compare value is a full `CNT_W`-bit (default 32) two's-complement number, and the block compares every bit of it.
- R7: If `cnt_en` is low while any bit of `slot_en` is set, then `cfg_err` is high in the next cycle, and no slot produces an event while `cnt_en` is low. Otherwise `cfg_err` is low in the next cycle.
- R8: Synchronous active-low reset clears every `out_bit`, every `irq`, `cfg_err` and the stored update history.
- R9: The previous-value history follows every strobe, including strobes given while `cnt_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_val | input | CNT_W | Counter value presented with the strobe |
| cnt_upd | input | 1 | Update strobe: cnt_val carries a new count |
| cnt_en | input | 1 | The counter is enabled |
| slot_en | input | SLOTS | Per-slot enable |
| slot_act | input | 2*SLOTS | Per-slot action code, slot s at bits [2s+1:2s] |
| slot_cmp | input | CNT_W*SLOTS | Per-slot compare value, slot s at bits [CNT_W*s +: CNT_W] |
| out_bit | output | SLOTS | Registered set/clear output bit per slot |
| irq | output | SLOTS | Single-cycle interrupt request per slot |
| cfg_err | output | 1 | Slot enabled while the counter is disabled |

## Verification
The stored previous value is the only hidden state. If it is wrong, a repeated or departing update shows up as a spurious pulse or bit flip one cycle after the strobe. A genuine arrival can also show up as a missing event in that same cycle. A stuck or mis-registered output bit appears at the very next compare against the reference, because the reference mirrors the hold behaviour in every cycle. Gating faults around `cnt_en` show up the cycle after the counter is disabled, either as `cfg_err` staying low or as an event that should not occur.

// File: rtl/cmpm_pkg.sv
// Package: shared action codes for the compare-match unit.
// Assumes: two-bit action field per slot; code values are part of the port contract.
package cmpm_pkg;
    typedef enum logic [1:0] {
        ACT_SET  = 2'b00,
        ACT_CLR  = 2'b01,
        ACT_IRQ  = 2'b10,
        ACT_NONE = 2'b11
    } cmpm_act_e;
endpackage

// File: rtl/cmpm_hist.sv
// Module: cmpm_hist
// Keeps the value carried by the most recent update strobe, plus a flag that
// says whether any strobe has been seen since reset.
// Assumes: every strobe is recorded, whether the counter is enabled or not.
module cmpm_hist #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd,
    input  logic [CNT_W-1:0] val,
    output logic [CNT_W-1:0] prev,
    output logic             prev_vld
);
    // Capture the new value on each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev     <= '0;
            prev_vld <= 1'b0;
        end else if (upd) begin
            prev     <= val;
            prev_vld <= 1'b1;
        end
    end

    // R9: a strobe always lands in the history one cycle later.
    assert_hist_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> (prev_vld && prev == $past(val)));
endmodule

// File: rtl/cmpm_slot.sv
// Module: cmpm_slot
// One compare slot. It detects an arrival of the new count at the compare
// value and applies the configured action to a registered bit or an
// interrupt pulse.
// Assumes: prev/prev_vld come from cmpm_hist and describe the value before
// this cycle's strobe; gate is low while the counter is disabled.
module cmpm_slot
    import cmpm_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd,
    input  logic [CNT_W-1:0] val,
    input  logic [CNT_W-1:0] prev,
    input  logic             prev_vld,
    input  logic             gate,
    input  logic             en,
    input  cmpm_act_e        act,
    input  logic [CNT_W-1:0] cmp,
    output logic             out_bit,
    output logic             irq
);
    logic at_cmp;
    logic was_cmp;
    logic hit;

    // Arrival test: the new value is on target and the old one was not.
    always_comb begin
        at_cmp  = (val == cmp);
        was_cmp = prev_vld && (prev == cmp);
        hit     = upd && gate && en && at_cmp && !was_cmp;
    end

    // Apply the set or clear action to the held output bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_bit <= 1'b0;
        end else if (hit && act == ACT_SET) begin
            out_bit <= 1'b1;
        end else if (hit && act == ACT_CLR) begin
            out_bit <= 1'b0;
        end
    end

    // Issue a one-cycle interrupt request per arrival.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else begin
            irq <= hit && (act == ACT_IRQ);
        end
    end

    assert_set_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && gate && en && act == ACT_SET && val == cmp &&
         !(prev_vld && prev == cmp)) |=> out_bit);
    assert_clr_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && gate && en && act == ACT_CLR && val == cmp &&
         !(prev_vld && prev == cmp)) |=> !out_bit);
    assert_leave_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && prev_vld && prev == cmp) |=> (!irq && $stable(out_bit)));
    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> (!irq && $stable(out_bit)));
    assert_irq_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    assert_quiet_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!en || act == ACT_NONE) |=> (!irq && $stable(out_bit)));
endmodule

// File: rtl/cmpm_top.sv
// Module: cmpm_top
// Compare-match unit: one shared history register feeding SLOTS compare
// slots, plus the flag for a slot enabled on a disabled counter.
// Assumes: cnt_val/cnt_upd come straight from the counter, and events are
// evaluated in the strobe cycle and appear one clock later.
module cmpm_top
    import cmpm_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int SLOTS = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [CNT_W-1:0]       cnt_val,
    input  logic                   cnt_upd,
    input  logic                   cnt_en,
    input  logic [SLOTS-1:0]       slot_en,
    input  logic [2*SLOTS-1:0]     slot_act,
    input  logic [CNT_W*SLOTS-1:0] slot_cmp,
    output logic [SLOTS-1:0]       out_bit,
    output logic [SLOTS-1:0]       irq,
    output logic                   cfg_err
);
    localparam int ACT_W = 2;

    logic [CNT_W-1:0] prev;
    logic             prev_vld;

    cmpm_hist #(.CNT_W(CNT_W)) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd      (cnt_upd),
        .val      (cnt_val),
        .prev     (prev),
        .prev_vld (prev_vld)
    );

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        cmpm_slot #(.CNT_W(CNT_W)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .upd      (cnt_upd),
            .val      (cnt_val),
            .prev     (prev),
            .prev_vld (prev_vld),
            .gate     (cnt_en),
            .en       (slot_en[s]),
            .act      (cmpm_act_e'(slot_act[ACT_W*s +: ACT_W])),
            .cmp      (slot_cmp[CNT_W*s +: CNT_W]),
            .out_bit  (out_bit[s]),
            .irq      (irq[s])
        );
    end

    // Flag a slot armed against a stopped counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_err <= 1'b0;
        end else begin
            cfg_err <= (|slot_en) && !cnt_en;
        end
    end

    assert_err_raise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((|slot_en) && !cnt_en) |=> cfg_err);
    assert_err_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_en |=> (irq == '0 && $stable(out_bit)));
    assert_reset_clear_R8: assert property (@(posedge clk)
        !rst_n |=> (irq == '0 && out_bit == '0 && !cfg_err));
endmodule

// File: tb/cmpm_top_tb.sv
module cmpm_top_tb;
    localparam int W = 32;
    localparam int N = 4;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [W-1:0]     cnt_val;
    logic             cnt_upd;
    logic             cnt_en;
    logic [N-1:0]     slot_en;
    logic [2*N-1:0]   slot_act;
    logic [W*N-1:0]   slot_cmp;
    logic [N-1:0]     out_bit;
    logic [N-1:0]     irq;
    logic             cfg_err;

    int checks = 0;
    int fails  = 0;

    // Reference state
    logic [W-1:0] m_prev;
    bit           m_pv;
    logic [N-1:0] m_out;
    logic [N-1:0] m_irq;
    bit           m_err;

    always #10 clk = ~clk;

    cmpm_top #(.CNT_W(W), .SLOTS(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_upd(cnt_upd),
        .cnt_en(cnt_en), .slot_en(slot_en), .slot_act(slot_act),
        .slot_cmp(slot_cmp), .out_bit(out_bit), .irq(irq), .cfg_err(cfg_err)
    );

    task automatic check(input string tag);
        checks++;
        if (out_bit !== m_out) begin
            fails++;
            $display("FAIL %s out_bit actual=%b expected=%b", tag, out_bit, m_out);
        end
        checks++;
        if (irq !== m_irq) begin
            fails++;
            $display("FAIL %s irq actual=%b expected=%b", tag, irq, m_irq);
        end
        checks++;
        if (cfg_err !== m_err) begin
            fails++;
            $display("FAIL %s cfg_err actual=%b expected=%b", tag, cfg_err, m_err);
        end
    endtask

    // One clock: reference advances from the present inputs, then compare.
    task automatic step(input string tag, input logic upd, input logic [W-1:0] v);
        logic [N-1:0] nirq;
        cnt_upd = upd;
        cnt_val = v;
        nirq = '0;
        for (int s = 0; s < N; s++) begin
            logic [W-1:0] c;
            bit arrive;
            c = slot_cmp[W*s +: W];
            arrive = upd && cnt_en && slot_en[s] && (v == c) && !(m_pv && m_prev == c);
            if (arrive) begin
                case (slot_act[2*s +: 2])
                    2'b00: m_out[s] = 1'b1;
                    2'b01: m_out[s] = 1'b0;
                    2'b10: nirq[s] = 1'b1;
                    default: ;
                endcase
            end
        end
        m_irq = nirq;
        m_err = (slot_en != '0) && !cnt_en;
        if (upd) begin
            m_prev = v;
            m_pv = 1'b1;
        end
        @(posedge clk);
        @(negedge clk);
        check(tag);
    endtask

    task automatic set_slot(input int s, input logic [1:0] a, input logic [W-1:0] c);
        slot_act[2*s +: 2] = a;
        slot_cmp[W*s +: W] = c;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cnt_val = '0; cnt_upd = 1'b0; cnt_en = 1'b1;
        slot_en = '1; slot_act = '0; slot_cmp = '0;
        m_prev = '0; m_pv = 1'b0; m_out = '0; m_irq = '0; m_err = 1'b0;
        set_slot(0, 2'b00, 32'd200);
        set_slot(1, 2'b00, 32'd100);
        set_slot(2, 2'b10, 32'd200);
        set_slot(3, 2'b10, 32'h7FFF_FFFF);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R8 reset state");
        rst_n = 1'b1;

        // Climb onto 200 from below, leave, return from above
        step("R1 first strobe", 1'b1, 32'd198);
        step("R1 approach", 1'b1, 32'd199);
        step("R1 R3 R4 arrive from below", 1'b1, 32'd200);
        step("R2 leave upward", 1'b1, 32'd201);
        step("R1 R4 arrive from above", 1'b1, 32'd200);
        step("R2 no strobe hold", 1'b0, 32'd200);
        step("R2 repeat value", 1'b1, 32'd200);
        step("R2 idle with stale value", 1'b0, 32'd999);

        // Set then clear slot 1 on a jump to 100
        step("R1 R3 jump set", 1'b1, 32'd100);
        set_slot(1, 2'b01, 32'd100);
        step("R3 leave", 1'b1, 32'd101);
        step("R3 clear on arrival", 1'b1, 32'd100);
        step("R2 leave down", 1'b1, 32'd99);

        // Signed wrap onto the largest positive value
        step("R6 min value", 1'b1, 32'h8000_0000);
        step("R1 R6 wrap arrival", 1'b1, 32'h7FFF_FFFF);
        set_slot(3, 2'b10, 32'hFFFF_FFFB);
        step("R6 near miss", 1'b1, 32'h7FFF_FFFB);
        step("R6 negative arrival", 1'b1, 32'hFFFF_FFFB);

        // No-action code and disabled slot
        set_slot(0, 2'b11, 32'd50);
        set_slot(2, 2'b10, 32'd50);
        slot_en[2] = 1'b0;
        step("R5 approach", 1'b1, 32'd49);
        step("R5 suppressed arrival", 1'b1, 32'd50);
        slot_en[2] = 1'b1;
        step("R5 reenabled leave", 1'b1, 32'd51);

        // Counter disabled while slots armed
        cnt_en = 1'b0;
        set_slot(1, 2'b00, 32'd60);
        step("R7 R9 err raised", 1'b1, 32'd60);
        step("R7 strobe ignored", 1'b1, 32'd50);
        step("R7 history during err", 1'b1, 32'd61);
        cnt_en = 1'b1;
        step("R7 R9 err clears, arrival after disabled strobes", 1'b1, 32'd60);
        step("R9 repeat after re-enable", 1'b1, 32'd60);
        slot_en = '0;
        cnt_en = 1'b0;
        step("R7 no slots no err", 1'b1, 32'd5);

        // Reset mid-run clears outputs and history
        slot_en = '1; cnt_en = 1'b1;
        rst_n = 1'b0;
        m_out = '0; m_irq = '0; m_err = 1'b0; m_pv = 1'b0; m_prev = '0;
        @(posedge clk);
        @(negedge clk);
        check("R8 mid-run reset");
        rst_n = 1'b1;
        step("R1 R8 first strobe after reset", 1'b1, 32'd60);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule